// File: doc/BRIEF.md
# Column-Parallel Single-Slope Conversion Capture

This block is the digital half of a column-parallel single-slope converter for a colour image sensor with a 2x2 red/green/blue mosaic. A line conversion starts on a line-start pulse: one shared 11-bit count then climbs from 0 to 2047, one step per clock, in step with the analog ramps. Each column keeps the count it held when its own comparator first went high. A comparator that never goes high leaves the full-scale code in its column.

Every column has two result slots. The line being converted is written into one slot while the line converted before it is sent out of the other, one pixel position per clock. Each outgoing word carries its value, its pixel position and a colour tag. Green pixels always go through odd-numbered columns, so on rows where green sits at even positions each neighbouring pixel pair is routed crosswise. The readout undoes that crossing. The block drives the routing-control output and the two ramp-run outputs. Besides full readout it offers a window mode and a sub-sampled mode that keeps the 2x2 colour cell intact.

Top module: `col_ss_adc_capture`

## Requirements
- R1: On the first clock after a line-start pulse the shared count is 0, and it rises by one per clock. A column whose comparator is sampled high at a clock edge keeps the count value present before that edge as its 11-bit result.
- R2: A column whose comparator is never sampled high during the 2048 conversion clocks stores 2047.
- R3: Only the first high sample of a column within a conversion is stored. Later low or high changes in the same conversion leave the result unchanged.
- R4: On a line-start pulse the line just converted starts to read out, with position 0 on the first clock after the pulse and one position per clock after that. If no conversion has completed (after reset), or if the previous conversion was cut short by an early line-start, there is no readout.
- R5: Rows are counted modulo 4. `col_swap` equals bit 0 of the row being converted. On a swapped row, pixel position p is converted in column p^1. The readout reports pixels in increasing spatial position with their own values.
- R6: The colour tag is 2'b00 for red, 2'b01 for green and 2'b10 for blue. A value from an odd column is tagged green. A value from an even column is tagged red on even rows and blue on odd rows.
- R7: `ramp_g_on` and `ramp_rb_on` are both high for exactly the 2048 clocks of a conversion and low otherwise.
- R8: With mode 2'b01, only positions p where win_lo <= p <= win_hi are output (both ends inclusive).
- R9: With mode 2'b10, only positions whose bit 1 is 0 are output, and only for rows whose row-count bit 1 is 0. Modes 2'b00 and 2'b11 output every position.
- R10: A line-start pulse that comes with `frame_start` high makes the new line row 0. Without `frame_start`, each line-start advances the row count by one, wrapping modulo 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start | input | 1 | One-clock pulse that begins a line conversion |
| frame_start | input | 1 | Qualifies line_start as row 0 of a frame |
| cmp | input | NCOLS | Per-column comparator outputs |
| mode | input | 2 | Readout mode: 00/11 full, 01 window, 10 sub-sampled |
| win_lo | input | PW | First pixel position of the window |
| win_hi | input | PW | Last pixel position of the window |
| col_swap | output | 1 | Pair-swap routing control for the row being converted |
| ramp_g_on | output | 1 | Run control for the green ramp (odd columns) |
| ramp_rb_on | output | 1 | Run control for the red/blue ramp (even columns) |
| px_valid | output | 1 | Output word strobe |
| px_data | output | DW | Converted pixel value |
| px_color | output | 2 | Colour tag of the pixel |
| px_col | output | PW | Spatial pixel position of the word |

## Verification
Each line drives a different spread of comparator switch points across the columns. The spread includes one column that never switches and some that switch on the last count. Every comparator drops low and rises again after its first switch, so a capture that reacts to a later edge shows up as a wrong value. Lines alternate between even and odd rows, which separates a correct un-swap and colour tag from a plain or half-done mirror. The window and sub-sampled modes are run on rows that should and should not produce output. An aborted line and a frame restart then check that readout is suppressed and that the row count restarts.

// File: rtl/col_ss_adc_capture.sv
module col_ss_adc_capture #(
  parameter int NCOLS = 16,
  parameter int DW    = 11,
  localparam int PW   = $clog2(NCOLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic             frame_start,
  input  logic [NCOLS-1:0] cmp,
  input  logic [1:0]       mode,
  input  logic [PW-1:0]    win_lo,
  input  logic [PW-1:0]    win_hi,
  output logic             col_swap,
  output logic             ramp_g_on,
  output logic             ramp_rb_on,
  output logic             px_valid,
  output logic [DW-1:0]    px_data,
  output logic [1:0]       px_color,
  output logic [PW-1:0]    px_col
);
  localparam logic [DW-1:0] CMAX = {DW{1'b1}};
  localparam logic [PW-1:0] LAST = PW'(NCOLS - 1);

  logic             conv, conv_done, bank, rd_on;
  logic [DW-1:0]    cnt;
  logic [NCOLS-1:0] got, hit;
  logic [1:0]       cap_row, rd_row;
  logic [PW-1:0]    rd_pos, rd_colm;
  logic [DW-1:0]    mem [2][NCOLS];
  logic             sel;

  assign hit = (conv && !line_start) ? (~got & (cmp | {NCOLS{cnt == CMAX}})) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv      <= 1'b0;
      conv_done <= 1'b0;
      cnt       <= '0;
      bank      <= 1'b0;
      got       <= '0;
      cap_row   <= '0;
      rd_row    <= '0;
      rd_on     <= 1'b0;
      rd_pos    <= '0;
    end else if (line_start) begin
      conv      <= 1'b1;
      conv_done <= 1'b0;
      cnt       <= '0;
      bank      <= ~bank;
      got       <= '0;
      rd_row    <= cap_row;
      cap_row   <= frame_start ? 2'd0 : cap_row + 2'd1;
      rd_on     <= conv_done && !(mode == 2'b10 && cap_row[1]);
      rd_pos    <= '0;
    end else begin
      got <= got | hit;
      if (conv) begin
        cnt <= cnt + 1'b1;
        if (cnt == CMAX) begin
          conv      <= 1'b0;
          conv_done <= 1'b1;
        end
      end
      if (rd_on) begin
        rd_pos <= rd_pos + 1'b1;
        if (rd_pos == LAST) rd_on <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCOLS; c++)
      if (hit[c]) mem[bank][c] <= cnt;
  end

  assign rd_colm = rd_pos ^ PW'(rd_row[0]);

  always_comb begin
    case (mode)
      2'b01:   sel = (rd_pos >= win_lo) && (rd_pos <= win_hi);
      2'b10:   sel = !rd_pos[1];
      default: sel = 1'b1;
    endcase
  end

  assign px_valid   = rd_on && sel;
  assign px_data    = mem[~bank][rd_colm];
  assign px_color   = rd_colm[0] ? 2'b01 : (rd_row[0] ? 2'b10 : 2'b00);
  assign px_col     = rd_pos;
  assign col_swap   = cap_row[0];
  assign ramp_g_on  = conv;
  assign ramp_rb_on = conv;

  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(conv) && !$past(line_start) && conv |-> cnt == $past(cnt) + 1'b1);

  assert_first_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(line_start) |-> (($past(got) & ~got) == '0));

  assert_spatial_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid && $past(px_valid) && !$past(line_start) |-> px_col > $past(px_col));

  assert_green_odd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |-> (px_color != 2'b11) && ((px_color == 2'b01) == (px_col[0] ^ rd_row[0])));

  assert_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid && mode == 2'b01 |-> px_col >= win_lo && px_col <= win_hi);

  assert_subsample_R9: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid && mode == 2'b10 |-> !px_col[1] && !rd_row[1]);
endmodule

// File: tb/sim_col_ss_adc_capture.sv
module sim_col_ss_adc_capture;
  localparam int NC = 16;
  localparam int PW = 4;

  logic          clk = 1'b0, rst_n = 1'b0, line_start = 1'b0, frame_start = 1'b0;
  logic [NC-1:0] cmp = '0;
  logic [1:0]    mode = 2'b00;
  logic [PW-1:0] win_lo = '0, win_hi = '0;
  logic          col_swap, ramp_g_on, ramp_rb_on, px_valid;
  logic [10:0]   px_data;
  logic [1:0]    px_color;
  logic [PW-1:0] px_col;

  col_ss_adc_capture #(.NCOLS(NC), .DW(11)) u0 (
    .clk, .rst_n, .line_start, .frame_start, .cmp, .mode, .win_lo, .win_hi,
    .col_swap, .ramp_g_on, .ramp_rb_on, .px_valid, .px_data, .px_color, .px_col);

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  int nobs = 0;
  int obs_v[64], obs_t[64], obs_p[64];
  int cur_v[NC], prev_v[NC];
  int row = 0, prev_row = 0;
  bit prev_ok = 0;

  always @(negedge clk) if (px_valid) begin
    if (nobs < 64) begin
      obs_v[nobs] = px_data; obs_t[nobs] = px_color; obs_p[nobs] = px_col;
    end
    nobs++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic convert_line(input bit fs, input int ncyc, input int seed);
    for (int c = 0; c < NC; c++) cur_v[c] = (seed * 37 + c * 113) % 2100;
    cur_v[(seed + 5) % NC] = 4000;
    cur_v[(seed + 9) % NC] = 2047;
    @(negedge clk);
    nobs = 0;
    if (fs) row = 0;
    line_start = 1'b1; frame_start = fs;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      line_start = 1'b0; frame_start = 1'b0;
      for (int c = 0; c < NC; c++) cmp[c] = (i == cur_v[c]) || (i >= cur_v[c] + 3);
      if (i == 5) begin
        chk(ramp_g_on && ramp_rb_on, "R7 ramps on", int'(ramp_g_on) + int'(ramp_rb_on), 2);
        chk(col_swap == row[0], "R5/R10 col_swap", col_swap, row[0]);
      end
      if (i == 2047)
        chk(ramp_g_on && ramp_rb_on, "R7 ramps on last count", int'(ramp_g_on), 1);
    end
    @(negedge clk);
    cmp = '0;
    if (ncyc >= 2048)
      chk(!ramp_g_on && !ramp_rb_on, "R7 ramps off", int'(ramp_g_on) + int'(ramp_rb_on), 0);
  endtask

  task automatic check_readout(input string tag);
    int k = 0;
    bit swp = prev_row[0];
    for (int p = 0; p < NC; p++) begin
      bit s;
      int c, ev, et;
      case (mode)
        2'b01:   s = (p >= win_lo) && (p <= win_hi);
        2'b10:   s = (p[1] == 1'b0) && (prev_row[1] == 0);
        default: s = 1'b1;
      endcase
      if (!prev_ok) s = 1'b0;
      if (!s) continue;
      c  = p ^ int'(swp);
      ev = (cur_v[0] >= 0 && prev_v[c] < 2047) ? prev_v[c] : 2047;
      et = (c % 2 == 1) ? 1 : (swp ? 2 : 0);
      if (k < nobs && k < 64) begin
        chk(obs_p[k] == p, {tag, " R5 position"}, obs_p[k], p);
        chk(obs_v[k] == ev, {tag, " R1/R2/R3/R5 value"}, obs_v[k], ev);
        chk(obs_t[k] == et, {tag, " R6 colour"}, obs_t[k], et);
      end
      k++;
    end
    chk(nobs == k, {tag, " R4/R8/R9 word count"}, nobs, k);
  endtask

  task automatic run_line(input bit fs, input int ncyc, input int seed,
                          input logic [1:0] m, input int lo, input int hi, input string tag);
    mode = m; win_lo = PW'(lo); win_hi = PW'(hi);
    convert_line(fs, ncyc, seed);
    check_readout(tag);
    prev_v   = cur_v;
    prev_row = row;
    prev_ok  = (ncyc >= 2048);
    row      = (row + 1) % 4;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(!px_valid, "R4 no output in reset", px_valid, 0);
    chk(!ramp_g_on && !ramp_rb_on, "R7 ramps idle in reset", int'(ramp_g_on), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!px_valid && col_swap == 1'b0, "R4/R5 idle after reset", px_valid, 0);
  endtask

  task automatic t_full_even;  run_line(1, 2048, 1, 2'b00, 0, 0, "first line");      endtask
  task automatic t_full_odd;   run_line(0, 2048, 2, 2'b00, 0, 0, "even row full");   endtask
  task automatic t_window;     run_line(0, 2048, 3, 2'b01, 3, 9, "odd row window");  endtask
  task automatic t_sub_skip;   run_line(1, 2048, 4, 2'b10, 0, 0, "row2 sub skipped"); endtask
  task automatic t_sub_keep;   run_line(0, 2048, 5, 2'b10, 0, 0, "row0 sub kept");   endtask
  task automatic t_abort;      run_line(0, 100,  6, 2'b11, 0, 0, "odd row full");    endtask
  task automatic t_after_abort; run_line(0, 2048, 7, 2'b00, 0, 0, "after abort");    endtask
  task automatic t_wrap;       run_line(0, 2048, 8, 2'b00, 0, 0, "row3 full");       endtask

  bit done = 0;
  initial begin
    t_reset();
    t_full_even();
    t_full_odd();
    t_window();
    t_sub_skip();
    t_sub_keep();
    t_abort();
    t_after_abort();
    t_wrap();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5 * 190000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule